// File: doc/BRIEF.md
# UART Transmit Framer

This block turns queued characters into asynchronous serial frames on a single transmit line. Characters are written into a small transmit store. The store is either a FIFO of configurable depth or a one-character holding register, chosen by a mode input. A shift stage then sends each character as a frame. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Bit timing comes from a one-per-bit tick input, because the baud generator sits outside the block.

The frame format is taken from a set of line-control inputs. These select the word length, whether parity is used, even or odd parity, stick parity and a second stop bit. The shift stage latches the format when it loads a character, so a change takes effect at the next character. The UART enable and the transmitter enable only decide whether a new character may start. A send-break input holds the line low, but only once the character in flight has ended. Status outputs report busy, store empty and store full.

Top module: `uart_tx_framer`

## Requirements
- R1: The line idles high. Each frame is a start bit (0), then the data bits LSB first, then the parity bit if parity is on, then the stop bit(s) (1). Each bit lasts from one `bit_tick` to the next. The start bit appears in the cycle after the tick that loads a character.
- R2: `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the word length are not sent.
- R3: With `par_en`=1 and `stick_par`=0, the parity bit makes the number of ones over data plus parity even when `even_sel`=1, and odd when `even_sel`=0.
- R4: With `par_en`=1 and `stick_par`=1, the parity bit is a constant 1 when `even_sel`=0 and a constant 0 when `even_sel`=1.
- R5: `two_stop`=1 appends a second high stop bit, which makes the frame one bit longer.
- R6: While `send_break` is 1, no new character is started. Once the character in progress has ended, `txd` is held low. After `send_break` returns to 0, `txd` returns high and queued characters resume.
- R7: A new character starts only when both `uart_en` and `tx_en` are 1. Clearing either one during a frame lets that frame finish, and the next queued character then waits.
- R8: `busy` is 1 whenever the store holds a character, whatever the enables are. It stays 1 until the tick that ends the last stop bit.
- R9: `tx_empty` and `tx_full` describe only the store, not the shift stage. The store holds `FIFO_DEPTH` characters when `fifo_en`=1 and 1 character when `fifo_en`=0. A write while full is dropped.
- R10: When a character is queued at the end of a frame, the next start bit follows the last stop bit directly, with no idle bit in between.
- R11: After reset, `txd`=1, `busy`=0, `tx_empty`=1 and `tx_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_valid | input | 1 | Write one character into the store |
| wr_data | input | 8 | Character to write |
| uart_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmitter enable |
| fifo_en | input | 1 | 1: FIFO store, 0: one-character holding register |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| even_sel | input | 1 | Even (1) or odd (0) parity |
| stick_par | input | 1 | Constant parity bit |
| two_stop | input | 1 | Second stop bit |
| send_break | input | 1 | Hold line low after the current frame |
| txd | output | 1 | Serial output |
| busy | output | 1 | Character stored or frame in flight |
| tx_empty | output | 1 | Store empty |
| tx_full | output | 1 | Store full |

## Verification
The bench builds the block with `FIFO_DEPTH`=4. This makes it possible to fill the FIFO, to see a write dropped while full, and to run a string of back-to-back frames in a short run. The format sweep covers all four word lengths, five parity settings (off, odd, even, stick-one, stick-zero) and both stop settings, each with several data bytes. Every frame is compared bit for bit with a frame the bench assembles by arithmetic. Directed sequences then cover disabling mid-frame, a break raised mid-frame, a store filled while the UART is disabled, and holding-register mode.

// File: rtl/uart_txf_pkg.sv
// Package: shared format type and frame assembly for the UART transmit framer.
// Assumes characters of at most 8 bits and frames of at most 12 bits.
package uart_txf_pkg;

    localparam int CHAR_W  = 8;
    localparam int FRAME_W = 12;
    localparam int LEN_W   = 4;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       even_sel;
        logic       stick;
        logic       two_stop;
    } txf_fmt_t;

    // Frame bits, LSB sent first; unused upper positions are ones.
    function automatic logic [FRAME_W-1:0] frame_bits(input logic [CHAR_W-1:0] d,
                                                      input txf_fmt_t f);
        logic [FRAME_W-1:0] v;
        logic [CHAR_W-1:0]  dm;
        logic               par;
        int                 n;
        v  = '1;
        dm = '0;
        n  = 5 + int'(f.wlen);
        v[0] = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < n) begin
                v[i+1] = d[i];
                dm[i]  = d[i];
            end
        end
        if (f.stick) par = ~f.even_sel;
        else         par = f.even_sel ? ^dm : ~^dm;
        if (f.par_en) v[n+1] = par;
        return v;
    endfunction

    // Total number of bits in a frame for this format.
    function automatic logic [LEN_W-1:0] frame_len(input txf_fmt_t f);
        return LEN_W'(7 + int'(f.wlen) + int'(f.par_en) + int'(f.two_stop));
    endfunction

endpackage

// File: rtl/txf_store.sv
// Transmit store: circular buffer with an occupancy counter.
// Assumes: DEPTH >= 1. In holding mode only one entry is used, so a write is
// dropped while anything is stored. Pop on empty and push on full are ignored.
module txf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_mode,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    // Occupancy-derived status.
    always_comb begin
        empty   = (count == '0);
        full    = hold_mode ? !empty : (count == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Entry storage; written only on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/txf_shifter.sv
// Frame shifter: loads a prepared frame on a bit tick and moves one bit per
// tick onto the line. When idle the line is high, or low if break was
// requested in the previous cycle.
// Assumes: start_ok already includes the enables, the break gate and "data
// available". A new frame may load on the tick that ends the previous one.
module txf_shifter
    import uart_txf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               start_ok,
    input  logic               send_break,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   len_in,
    output logic               load,
    output logic               active,
    output logic               txd
);
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;
    logic               brk_q;
    logic               last;

    // Load decision and line output.
    always_comb begin
        last = (left == '0);
        load = bit_tick && start_ok && (!active || last);
        txd  = active ? sh[0] : !brk_q;
    end

    // Shift register, bit counter and break register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '1;
            left   <= '0;
            active <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            brk_q <= send_break;
            if (load) begin
                sh     <= frame_in;
                left   <= len_in - 1'b1;
                active <= 1'b1;
            end else if (bit_tick && active) begin
                if (last) begin
                    active <= 1'b0;
                end else begin
                    sh   <= {1'b1, sh[FRAME_W-1:1]};
                    left <= left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
// UART transmit framer top. It connects the transmit store to the frame shifter
// and assembles each frame from the format inputs at load time.
// Assumes: bit_tick is a one-cycle pulse at the bit rate, generated outside.
module uart_tx_framer
    import uart_txf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       uart_en,
    input  logic       tx_en,
    input  logic       fifo_en,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       even_sel,
    input  logic       stick_par,
    input  logic       two_stop,
    input  logic       send_break,
    output logic       txd,
    output logic       busy,
    output logic       tx_empty,
    output logic       tx_full
);
    logic [CHAR_W-1:0]  head;
    logic               st_empty, st_full;
    logic               do_load, sh_active, start_ok;
    txf_fmt_t           fmt;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   flen;

    txf_store #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_mode (!fifo_en),
        .push      (wr_valid),
        .din       (wr_data),
        .pop       (do_load),
        .dout      (head),
        .empty     (st_empty),
        .full      (st_full)
    );

    // Format capture, frame assembly and start gating.
    always_comb begin
        fmt      = '{wlen: word_len, par_en: par_en, even_sel: even_sel,
                     stick: stick_par, two_stop: two_stop};
        frame    = frame_bits(head, fmt);
        flen     = frame_len(fmt);
        start_ok = uart_en && tx_en && !send_break && !st_empty;
    end

    txf_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .start_ok   (start_ok),
        .send_break (send_break),
        .frame_in   (frame),
        .len_in     (flen),
        .load       (do_load),
        .active     (sh_active),
        .txd        (txd)
    );

    // Status outputs.
    always_comb begin
        busy     = !st_empty || sh_active;
        tx_empty = st_empty;
        tx_full  = st_full;
    end
endmodule

// File: rtl/uart_tx_framer_chk.sv
// Checker for uart_tx_framer, attached with bind. It relates the ports to the
// shifter's active flag and load strobe.
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic uart_en,
    input logic tx_en,
    input logic fifo_en,
    input logic send_break,
    input logic txd,
    input logic busy,
    input logic tx_empty,
    input logic tx_full,
    input logic active,
    input logic pop
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(send_break)) |-> txd); // R1
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(bit_tick)) |-> $stable(txd)); // R1
    AST_BREAK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && send_break) |=> !active); // R6
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(uart_en && tx_en)) |=> !active); // R7
    AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> busy); // R8
    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_empty && tx_full)); // R9
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !pop && fifo_en) |=> tx_full); // R9
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .uart_en    (uart_en),
    .tx_en      (tx_en),
    .fifo_en    (fifo_en),
    .send_break (send_break),
    .txd        (txd),
    .busy       (busy),
    .tx_empty   (tx_empty),
    .tx_full    (tx_full),
    .active     (sh_active),
    .pop        (do_load)
);

// File: tb/test_uart_tx_framer.sv
`timescale 1ns/1ps
module test_uart_tx_framer;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       uart_en = 1'b0, tx_en = 1'b1, fifo_en = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0, two_stop = 1'b0;
    logic       send_break = 1'b0;
    logic       txd, busy, tx_empty, tx_full;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_tx_framer #(.FIFO_DEPTH(DEPTH)) i_uart_tx_framer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .uart_en(uart_en), .tx_en(tx_en), .fifo_en(fifo_en),
        .word_len(word_len), .par_en(par_en), .even_sel(even_sel),
        .stick_par(stick_par), .two_stop(two_stop), .send_break(send_break),
        .txd(txd), .busy(busy), .tx_empty(tx_empty), .tx_full(tx_full)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Expected frame assembled by shifting bits in at the current length.
    task automatic expect_frame(input logic [7:0] d, output logic [11:0] v,
                                output int len);
        int n;
        int ones;
        logic pb;
        n = 5 + int'(word_len);
        v = 12'hFFF;
        len = 0;
        ones = 0;
        v[len] = 1'b0; len++;
        for (int i = 0; i < n; i++) begin
            v[len] = d[i]; len++;
            ones += int'(d[i]);
        end
        if (par_en) begin
            if (stick_par) pb = !even_sel;
            else if (even_sel) pb = (ones % 2) == 1;
            else pb = (ones % 2) == 0;
            v[len] = pb; len++;
        end
        v[len] = 1'b1; len++;
        if (two_stop) begin v[len] = 1'b1; len++; end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    // One tick edge, then sample at the following negedge.
    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    // Capture bits [from, len) of a frame, one per tick.
    task automatic grab(inout logic [11:0] cap, input int from, input int len,
                        output logic busy_last);
        busy_last = 1'b0;
        for (int i = from; i < len; i++) begin
            tick();
            cap[i] = txd;
            busy_last = busy;
        end
    endtask

    task automatic run_frame(input logic [7:0] d, input string tag);
        logic [11:0] exp, cap;
        int len;
        logic bl;
        expect_frame(d, exp, len);
        cap = 12'hFFF;
        grab(cap, 0, len, bl);
        check(cap == exp, tag, 32'(cap), 32'(exp));
        check(bl == 1'b1, "R8 busy at last stop bit", 32'(bl), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] exp, cap;
        int len;
        logic bl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(txd == 1'b1, "R11 txd", 32'(txd), 1);
        check(busy == 1'b0, "R11 busy", 32'(busy), 0);
        check(tx_empty == 1'b1, "R11 tx_empty", 32'(tx_empty), 1);
        check(tx_full == 1'b0, "R11 tx_full", 32'(tx_full), 0);

        // R8: a stored character sets busy even while disabled
        push(8'h3C);
        check(busy == 1'b1, "R8 busy while disabled", 32'(busy), 1);
        check(tx_empty == 1'b0, "R9 not empty", 32'(tx_empty), 0);
        tick(); tick();
        check(txd == 1'b1, "R7 no start while disabled", 32'(txd), 1);
        uart_en = 1'b1;
        run_frame(8'h3C, "R1 basic frame");
        tick();
        check(txd == 1'b1 && busy == 1'b0, "R1 idle after frame",
              {30'd0, txd, busy}, 32'd2);

        // Format sweep: R2 word length, R3 parity, R4 stick, R5 stops
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 5; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int di = 0; di < 3; di++) begin
                        string tag;
                        logic [7:0] d;
                        d = 8'((wl * 37) + (pm * 11) + (st * 5) + (di * 73) + 90);
                        word_len = 2'(wl);
                        par_en = (pm != 0);
                        even_sel = (pm == 2) || (pm == 4);
                        stick_par = (pm >= 3);
                        two_stop = (st == 1);
                        if (st == 1) tag = "R5 two stop";
                        else if (pm >= 3) tag = "R4 stick parity";
                        else if (pm >= 1) tag = "R3 parity";
                        else tag = "R2 word length";
                        push(d);
                        run_frame(d, tag);
                    end
                end
            end
        end
        word_len = 2'd3; par_en = 0; even_sel = 0; stick_par = 0; two_stop = 0;
        tick();

        // R9: empty reflects the store only
        push(8'h81);
        tick();
        check(tx_empty == 1'b1 && busy == 1'b1, "R9 empty excludes shifter",
              {30'd0, tx_empty, busy}, 32'd3);
        expect_frame(8'h81, exp, len);
        cap = 12'hFFF; cap[0] = txd;
        grab(cap, 1, len, bl);
        check(cap == exp, "R1 frame after status check", 32'(cap), 32'(exp));

        // R7: disable mid-frame, the frame completes and the next waits
        push(8'hA7); push(8'h19);
        tick();
        expect_frame(8'hA7, exp, len);
        cap = 12'hFFF; cap[0] = txd;
        tx_en = 1'b0;
        grab(cap, 1, len, bl);
        check(cap == exp, "R7 frame completes after disable", 32'(cap), 32'(exp));
        tick(); tick();
        check(txd == 1'b1 && busy == 1'b1 && tx_empty == 1'b0, "R7 next waits",
              {29'd0, txd, busy, tx_empty}, 32'd6);
        tx_en = 1'b1;
        run_frame(8'h19, "R7 resumes after enable");
        tick();

        // R6: break raised mid-frame
        push(8'h5E); push(8'hC3);
        tick();
        expect_frame(8'h5E, exp, len);
        cap = 12'hFFF; cap[0] = txd;
        grab(cap, 1, 3, bl);
        send_break = 1'b1;
        grab(cap, 3, len, bl);
        check(cap == exp, "R6 frame completes under break", 32'(cap), 32'(exp));
        tick();
        check(txd == 1'b0, "R6 line low after frame", 32'(txd), 0);
        tick(); tick();
        check(txd == 1'b0 && tx_empty == 1'b0, "R6 held low, no start",
              {30'd0, txd, tx_empty}, 32'd0);
        @(negedge clk); send_break = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R6 line high after break", 32'(txd), 1);
        run_frame(8'hC3, "R6 resumes after break");
        tick();

        // R9 FIFO full, dropped write; R10 back-to-back frames
        uart_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) push(8'(8'h40 + k * 17));
        check(tx_full == 1'b1, "R9 full at depth", 32'(tx_full), 1);
        push(8'hEE);
        uart_en = 1'b1;
        for (int k = 0; k < DEPTH; k++) run_frame(8'(8'h40 + k * 17), "R10 back-to-back");
        tick();
        check(txd == 1'b1 && busy == 1'b0, "R9 write while full dropped",
              {30'd0, txd, busy}, 32'd2);

        // R9 holding-register mode: depth one
        fifo_en = 1'b0;
        uart_en = 1'b0;
        push(8'h6B);
        check(tx_full == 1'b1, "R9 holding full", 32'(tx_full), 1);
        push(8'h22);
        uart_en = 1'b1;
        run_frame(8'h6B, "R9 holding frame");
        tick();
        check(txd == 1'b1 && busy == 1'b0, "R9 holding second write dropped",
              {30'd0, txd, busy}, 32'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule